// File: doc/BRIEF.md
# Keyed Watchdog Timer with Selectable Prescaler

This block is a watchdog timer behind a small 32-bit register port. A 16-bit up-counter advances once per prescaled tick while the enable bit is set. The tick rate comes from a 3-bit code that picks one of eight divisors: 1, 4, 16, 32, 64, 128, 1024 or 4096. When the counter steps past its all-ones value, it wraps to zero, sets a sticky overflow flag and raises a fixed-length system reset request. Software arms a timeout of N ticks by loading 65536 minus N into the counter.

Every register write has to carry a fixed key in its upper bits. A write without the key is dropped. An accepted write is staged and reaches the counting logic a fixed number of cycles later. While the value is in transit, a busy bit reads as 1. Software polls that bit before it issues a write that depends on the previous one. Any write that arrives while the busy bit is set is discarded.

Top module: `wdt_keyed_top`

## Requirements
- R1: After reset the counter reads 0, the control/status byte reads 0 and `rst_req` is low.
- R2: A write to address 0 with bits [31:16] equal to 16'h5A5A loads bits [15:0] into the counter.
- R3: A write to address 1 with bits [31:8] equal to 24'hA5A5A5 applies the control byte. Bit 7 is the enable and bits [2:0] are the divisor code.
- R4: A write whose key does not match leaves the counter and the control/status byte unchanged and does not set the busy bit.
- R5: After a keyed write is accepted, status bit 5 reads 1 for SYNC_STAGES cycles. The written value takes effect when bit 5 returns to 0. A write that arrives while bit 5 is 1 is ignored.
- R6: The counter advances by one every D clock cycles only while the enable is set. D is 1, 4, 16, 32, 64, 128, 1024 or 4096 for codes 0 through 7. With the enable clear, the counter holds its value.
- R7: On the step past 16'hFFFF the counter wraps to 0 and status bit 4 (overflow) is set. A load of 65536−N therefore overflows after N ticks.
- R8: The overflow flag is sticky. Only an applied keyed control write with bit 4 equal to 0 clears it. Writing bit 4 as 1 leaves it unchanged.
- R9: Each overflow drives `rst_req` high for exactly RST_LEN consecutive cycles.
- R10: A read of address 0 returns the counter in bits [15:0]. A read of address 1 returns {enable, 0, busy, overflow, 0, code} in bits [7:0]. All other bits read 0.
- R11: Applying a counter write restarts the prescaler from zero, so the next tick comes a full divisor period later.
- R12: With the counter at 16'hFFFF, code 0 and the enable applied, `rst_req` rises within three cycles after the enable takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 1 | Write target: 0 counter, 1 control/status |
| wr_data | input | 32 | Write data, key in upper bits |
| rd_addr | input | 1 | Read select: 0 counter, 1 control/status |
| rd_data | output | 32 | Read data, combinational on rd_addr |
| rst_req | output | 1 | System reset request pulse |

## Verification
The bench builds the block with its defaults: a 16-bit counter, a two-cycle transfer and a four-cycle reset pulse. Because the counter is 16 bits wide, loads within a few counts of 16'hFFFF reach an overflow in only a few ticks. This keeps the all-ones wrap, the sticky flag and the pulse length within a short run even with the 4096 divisor. The two-cycle transfer window is short enough that back-to-back writes hit the busy window on purpose. A behavioural model tracks every register across all eight divisor codes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int PRE_W = 12;
  localparam logic [15:0] CNT_KEY = 16'h5A5A;
  localparam logic [23:0] CTL_KEY = 24'hA5A5A5;
  localparam int BIT_EN   = 7;
  localparam int BIT_BUSY = 5;
  localparam int BIT_OVF  = 4;

  // terminal prescaler value (divisor - 1) for each code
  function automatic logic [PRE_W-1:0] pre_limit(input logic [2:0] code);
    case (code)
      3'd0:    pre_limit = PRE_W'(0);
      3'd1:    pre_limit = PRE_W'(3);
      3'd2:    pre_limit = PRE_W'(15);
      3'd3:    pre_limit = PRE_W'(31);
      3'd4:    pre_limit = PRE_W'(63);
      3'd5:    pre_limit = PRE_W'(127);
      3'd6:    pre_limit = PRE_W'(1023);
      default: pre_limit = PRE_W'(4095);
    endcase
  endfunction
endpackage

// File: rtl/wdt_key_gate.sv
module wdt_key_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  output logic        busy,
  output logic        apply_cnt,
  output logic        apply_ctl,
  output logic [15:0] apply_val
);
  import wdt_pkg::*;
  localparam int XW = $clog2(SYNC_STAGES + 1);

  logic [XW-1:0] xfer_q, xfer_d;
  logic          tgt_q, tgt_d;
  logic [15:0]   val_q, val_d;
  logic          key_ok, accept;

  assign key_ok = wr_addr ? (wr_data[31:8] == CTL_KEY) : (wr_data[31:16] == CNT_KEY);
  assign busy   = (xfer_q != '0);
  assign accept = wr_en && key_ok && !busy;

  always_comb begin
    xfer_d = xfer_q;
    tgt_d  = tgt_q;
    val_d  = val_q;
    if (accept) begin
      xfer_d = XW'(SYNC_STAGES);
      tgt_d  = wr_addr;
      val_d  = wr_data[15:0];
    end else if (busy) begin
      xfer_d = xfer_q - XW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_q <= '0;
      tgt_q  <= 1'b0;
      val_q  <= '0;
    end else begin
      xfer_q <= xfer_d;
      tgt_q  <= tgt_d;
      val_q  <= val_d;
    end
  end

  assign apply_cnt = (xfer_q == XW'(1)) && !tgt_q;
  assign apply_ctl = (xfer_q == XW'(1)) && tgt_q;
  assign apply_val = val_q;

  p_badkey_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !key_ok && !busy) |=> !busy);
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy);
  p_busy_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_cnt || apply_ctl) |=> !busy);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       clr,
  input  logic [2:0] code,
  output logic       tick
);
  import wdt_pkg::*;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] lim;

  assign lim  = pre_limit(code);
  assign tick = run && (pre_q >= lim);

  always_comb begin
    pre_d = pre_q;
    if (clr)       pre_d = '0;
    else if (tick) pre_d = '0;
    else if (run)  pre_d = pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  p_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (pre_q == '0));
  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(pre_q));
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [15:0]      load_val,
  input  logic             clr_ovf,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf,
  output logic             rst_req
);
  localparam int PW = $clog2(RST_LEN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [PW-1:0]    pls_q, pls_d;
  logic             ovf_evt;

  assign ovf_evt = tick && (&cnt_q) && !load;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val[CNT_W-1:0];
    else if (tick) cnt_d = cnt_q + CNT_W'(1);

    ovf_d = ovf_q;
    if (ovf_evt)      ovf_d = 1'b1;
    else if (clr_ovf) ovf_d = 1'b0;

    pls_d = pls_q;
    if (ovf_evt)            pls_d = PW'(RST_LEN);
    else if (pls_q != '0)   pls_d = pls_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
      pls_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
      pls_q <= pls_d;
    end
  end

  assign cnt     = cnt_q;
  assign ovf     = ovf_q;
  assign rst_req = (pls_q != '0);

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !clr_ovf) |=> ovf_q);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (cnt_q == '0 && ovf_q && rst_req));
  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |=> rst_req);
endmodule

// File: rtl/wdt_keyed_top.sv
module wdt_keyed_top #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_LEN     = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_addr,
  input  logic [31:0] wr_data,
  input  logic        rd_addr,
  output logic [31:0] rd_data,
  output logic        rst_req
);
  import wdt_pkg::*;

  logic [1:0]       rsync_q;
  logic             rst_i;
  logic             busy, apply_cnt, apply_ctl;
  logic [15:0]      apply_val;
  logic             en_q, en_d;
  logic [2:0]       code_q, code_d;
  logic             tick, ovf, clr_ovf;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       ctl_byte;

  // reset: asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i = rsync_q[1];

  wdt_key_gate #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .apply_cnt(apply_cnt),
    .apply_ctl(apply_ctl), .apply_val(apply_val)
  );

  always_comb begin
    en_d   = en_q;
    code_d = code_q;
    if (apply_ctl) begin
      en_d   = apply_val[BIT_EN];
      code_d = apply_val[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      en_q   <= 1'b0;
      code_q <= 3'd0;
    end else begin
      en_q   <= en_d;
      code_q <= code_d;
    end
  end

  assign clr_ovf = apply_ctl && !apply_val[BIT_OVF];

  wdt_prescaler u_pre (
    .clk(clk), .rst_n(rst_i), .run(en_q), .clr(apply_cnt),
    .code(code_q), .tick(tick)
  );

  wdt_core #(.CNT_W(CNT_W), .RST_LEN(RST_LEN)) u_core (
    .clk(clk), .rst_n(rst_i), .tick(tick), .load(apply_cnt),
    .load_val(apply_val), .clr_ovf(clr_ovf), .cnt(cnt), .ovf(ovf),
    .rst_req(rst_req)
  );

  always_comb begin
    ctl_byte = 8'h00;
    ctl_byte[BIT_EN]   = en_q;
    ctl_byte[BIT_BUSY] = busy;
    ctl_byte[BIT_OVF]  = ovf;
    ctl_byte[2:0]      = code_q;
  end

  assign rd_data = rd_addr ? {24'h0, ctl_byte} : {{(32-CNT_W){1'b0}}, cnt};

  p_ctl_stable_r3: assert property (@(posedge clk) disable iff (!rst_i)
    !apply_ctl |=> ($stable(en_q) && $stable(code_q)));
  p_no_count_idle_r6: assert property (@(posedge clk) disable iff (!rst_i)
    !en_q |-> !tick);
endmodule

// File: tb/wdt_keyed_top_tb.sv
`timescale 1ns/1ps
module wdt_keyed_top_tb;
  localparam int SYNC = 2;
  localparam int RLEN = 4;

  logic        clk, rst_n, wr_en, wr_addr, rd_addr, rst_req;
  logic [31:0] wr_data, rd_data;

  int n_chk, n_err;

  // behavioural reference state
  int m_cnt, m_pre, m_en, m_code, m_ovf, m_busy, m_ptgt, m_pval, m_pls, m_rs;

  wdt_keyed_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .rst_req(rst_req)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int divisor(input int c);
    case (c)
      0: return 1;    1: return 4;    2: return 16;   3: return 32;
      4: return 64;   5: return 128;  6: return 1024; default: return 4096;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_read(input bit a);
    if (a) return (m_en << 7) | ((m_busy != 0) << 5) | (m_ovf << 4) | m_code;
    return m_cnt;
  endfunction

  // reference model, updated at each rising edge, compared just after it
  initial begin
    m_rs = 0;
    forever begin
      @(posedge clk);
      if (!rst_n || m_rs < 2) begin
        if (!rst_n) m_rs = 0; else m_rs++;
        m_cnt = 0; m_pre = 0; m_en = 0; m_code = 0; m_ovf = 0;
        m_busy = 0; m_ptgt = 0; m_pval = 0; m_pls = 0;
      end else begin
        bit keyok, acc, ap, tk, ev;
        int lim;
        keyok = wr_addr ? (wr_data[31:8] == 24'hA5A5A5) : (wr_data[31:16] == 16'h5A5A);
        acc = wr_en && keyok && (m_busy == 0);
        ap  = (m_busy == 1);
        lim = divisor(m_code) - 1;
        tk  = m_en && (m_pre >= lim);
        ev  = tk && (m_cnt == 65535) && !(ap && m_ptgt == 0);
        if (m_pls > 0) m_pls--;
        if (ev) begin m_pls = RLEN; m_ovf = 1; end
        else if (ap && m_ptgt == 1 && ((m_pval >> 4) & 1) == 0) m_ovf = 0;
        if (ap && m_ptgt == 0) begin m_cnt = m_pval; m_pre = 0; end
        else begin
          if (tk) begin m_cnt = (m_cnt + 1) % 65536; m_pre = 0; end
          else if (m_en) m_pre++;
        end
        if (ap && m_ptgt == 1) begin m_en = (m_pval >> 7) & 1; m_code = m_pval & 7; end
        if (acc) begin m_busy = SYNC; m_ptgt = wr_addr; m_pval = wr_data[15:0]; end
        else if (m_busy > 0) m_busy--;
      end
      #1;
      if (rst_n && m_rs >= 2) begin
        chk(rd_data == model_read(rd_addr), "R10 read", rd_data, model_read(rd_addr));
        chk(rst_req == (m_pls != 0), "R9 rst_req", rst_req, m_pls != 0);
      end
    end
  end

  task automatic wr(input bit a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = 32'h0;
  endtask

  task automatic rd(input bit a, output logic [31:0] d);
    @(negedge clk); rd_addr = a; #0.5; d = rd_data;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_req(input int max, output int n);
    n = 0;
    while (!rst_req && n < max) begin @(negedge clk); n++; end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int n, hi;
    n_chk = 0; n_err = 0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 32'h0; rd_addr = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(5);

    rd(0, v); chk(v == 32'h0, "R1 counter", v, 0);
    rd(1, v); chk(v == 32'h0, "R1 control", v, 0);
    chk(rst_req == 1'b0, "R1 rst_req", rst_req, 0);

    wr(0, 32'h5A5A_FFF0);
    rd(1, v); chk(v[5] == 1'b1, "R5 busy after write", v[5], 1);
    step(3);
    rd(1, v); chk(v[5] == 1'b0, "R5 busy cleared", v[5], 0);
    rd(0, v); chk(v == 32'h0000_FFF0, "R2 counter load", v, 32'hFFF0);

    wr(0, 32'h5A5B_1234);
    rd(1, v); chk(v[5] == 1'b0, "R4 no busy on bad key", v[5], 0);
    step(3);
    rd(0, v); chk(v == 32'h0000_FFF0, "R4 counter unchanged", v, 32'hFFF0);
    wr(1, 32'hA5A5A4_80);
    step(3);
    rd(1, v); chk(v == 32'h0, "R4 control unchanged", v, 0);

    wr(1, 32'hA5A5A5_80);
    step(3);
    rd(1, v); chk(v == 32'h80, "R3 enable applied", v, 32'h80);
    wait_req(100, n);
    chk(rst_req == 1'b1, "R7 overflow reached", rst_req, 1);
    hi = 0;
    while (rst_req) begin @(negedge clk); hi++; end
    chk(hi == RLEN, "R9 pulse length", hi, RLEN);
    rd(1, v); chk(v[4] == 1'b1, "R7 overflow flag", v[4], 1);

    wr(1, 32'hA5A5A5_90);
    step(3);
    rd(1, v); chk(v[4] == 1'b1, "R8 flag kept on bit4=1", v[4], 1);
    wr(1, 32'hA5A5A5_80);
    step(3);
    rd(1, v); chk(v[4] == 1'b0, "R8 flag cleared", v[4], 0);

    wr(1, 32'hA5A5A5_00);
    step(4);
    rd(0, v); step(10); rd(0, v2);
    chk(v == v2, "R6 hold while disabled", v2, v);

    wr(0, 32'h5A5A_1111);
    wr(1, 32'hA5A5A5_87);
    step(4);
    rd(1, v); chk(v == 32'h0, "R5 write during busy ignored", v, 0);
    rd(0, v); chk(v == 32'h1111, "R5 first write applied", v, 32'h1111);

    for (int k = 0; k < 8; k++) begin
      wr(0, 32'h5A5A_FFFE);
      step(3);
      wr(1, 32'hA5A5A5_80 | k);
      wait_req(3 * 4096, n);
      chk(n >= 2 * divisor(k) && n <= 2 * divisor(k) + 8, "R6 divisor timing", n, 2 * divisor(k));
      step(RLEN + 1);
      wr(1, 32'hA5A5A5_00);
      step(3);
    end

    wr(0, 32'h5A5A_FFFF);
    step(3);
    wr(1, 32'hA5A5A5_87);
    step(3000);
    wr(0, 32'h5A5A_FFFF);
    step(2);
    wait_req(9000, n);
    chk(n >= 4000 && rst_req, "R11 prescaler restart", n, 4096);
    step(RLEN + 1);
    wr(1, 32'hA5A5A5_00);
    step(3);

    wr(0, 32'h5A5A_FFFF);
    step(3);
    wr(1, 32'hA5A5A5_80);
    step(1);
    wait_req(20, n);
    chk(rst_req && n <= 3, "R12 fast overflow", n, 3);
    step(10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule